// File: doc/BRIEF.md
# Self-Clearing Command Trigger Register

This block is the write-mostly command register of a four-channel DAC controller. Each write to it is turned into action pulses that last one clock. A soft reset fires only when its field holds an exact code. Load and clear strobes go to each channel according to that channel's configuration inputs. Further pulses start the NVM program, NVM reload, fault-dump, single-row fault-dump read and protect actions. Every trigger bit clears itself. A read returns a trigger bit only in the cycle its pulse is high, and returns 0 after that.

The block also holds the device lock bit of a neighbouring common configuration register. A small state machine guards that bit, with three states: LOCKED, ARMED and OPEN. The transition ARM goes from LOCKED to ARMED on a command write whose key field is 0101. The transition UNLOCK goes from ARMED to OPEN when the very next write clears the lock bit. The transition DISARM goes from ARMED back to LOCKED on any other write, unless that write re-arms. The transition RELOCK goes from OPEN to LOCKED on a write that sets the lock bit. The register sits on page FFh at address E4h. The lock bit is bit 0 of the configuration register at E3h on the same page.

Top module: `cmd_trig_reg`

## Requirements
- R1: After reset every pulse output is 0, every clear code is 0, reads return 0 from the command register, and the device is locked (`dev_locked`=1, state LOCKED).
- R2: A command write sets bit 0 (`nvm_reload_pulse`), bit 1 (`nvm_prog_pulse`), bit 2 (`rdrow_pulse`), bit 3 (`protect_pulse`) or bit 4 (`fdump_pulse`). Each set bit raises its output for exactly the one cycle after the write.
- R3: `soft_rst_pulse` rises for one cycle only when bits 11..8 of a command write equal 1010. Any other code on those bits gives no pulse.
- R4: A command write with bit 7 set and bit 6 clear raises `load_pulse[i]` for one cycle. This happens only for channels whose `sync_cfg[i]` is 1 at the time of the write.
- R5: A command write with bit 6 set raises every `clr_pulse[i]` for one cycle. It also sets that channel's 12-bit code in `clr_code` (bits 12i+11..12i) to 0x800 when `clr_sel[i]`=1 and to 0x000 otherwise. The code then holds until the next clear.
- R6: When bits 7 and 6 are set in the same write, the clear takes effect and no channel gets a load pulse.
- R7: A write of 0101 to bits 15..12, followed directly by a write of 0 to the lock bit, clears `dev_locked` (ARM, then UNLOCK).
- R8: The armed state is used up by the next bus write of any kind. A lock-bit clear without a directly preceding 0101 key is ignored. A key other than 0101 does not arm.
- R9: A write of 1 to the lock bit sets `dev_locked` from any state (RELOCK, DISARM).
- R10: A read of the command register returns 0101 in bits 15..12 while armed, 1010 in bits 11..8 during the soft-reset pulse cycle, and the written bits 7, 6 and 4..0 during their pulse cycle. It returns 0 in those fields otherwise, and bit 5 always reads 0. A read of the configuration register returns the lock bit in bit 0.
- R11: Writes to any other page or address raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_page | input | 8 | Page select |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| sync_cfg | input | 4 | Per-channel permission for the load strobe |
| clr_sel | input | 4 | Per-channel clear target: 1 mid code, 0 zero code |
| load_pulse | output | 4 | Per-channel load strobe |
| clr_pulse | output | 4 | Per-channel clear strobe |
| clr_code | output | 48 | Per-channel clear code, 12 bits per channel |
| soft_rst_pulse | output | 1 | Soft reset request |
| fdump_pulse | output | 1 | Fault-dump start |
| protect_pulse | output | 1 | Protect trigger |
| rdrow_pulse | output | 1 | Single-row fault-dump read |
| nvm_prog_pulse | output | 1 | NVM program start |
| nvm_reload_pulse | output | 1 | NVM reload start |
| dev_locked | output | 1 | Device lock bit |

## Verification
The assertions check these rules on every cycle:
- OPEN is entered only from ARMED.
- An armed state never survives a write that is not a key write.
- A lock-set write always leaves the device locked.
- A soft-reset pulse always follows a 1010 code.
- A load pulse appears only on a channel that allows it, and never while a clear pulses.
- Clear codes change only with a clear pulse.
- No pulse follows a cycle without a command write.

Some behaviour only the bench scenarios can show:
- That each pulse lands on the right output in the right cycle.
- That non-matching reset and key codes are ignored.
- The exact 0x800 and 0x000 clear codes.
- The readback values.
- The full ARM, UNLOCK, DISARM and RELOCK sequences, checked against a behavioural model.

// File: rtl/cmd_trig_pkg.sv
package cmd_trig_pkg;
    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_ARMED  = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_e;

    localparam logic [3:0] UNLOCK_KEY = 4'b0101;
    localparam logic [3:0] RESET_KEY  = 4'b1010;

    typedef struct packed {
        logic fdump;
        logic protect;
        logic rdrow;
        logic nvm_prog;
        logic nvm_reload;
    } misc_pulse_t;
endpackage

// File: rtl/lock_fsm.sv
module lock_fsm
    import cmd_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_wr,
    input  logic key_wr,
    input  logic clear_wr,
    input  logic set_wr,
    output logic locked,
    output logic armed
);
    lock_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: begin
                if (key_wr) state_d = LK_ARMED;        // ARM
            end
            LK_ARMED: begin
                if (clear_wr)    state_d = LK_OPEN;    // UNLOCK
                else if (key_wr) state_d = LK_ARMED;   // re-ARM
                else if (any_wr) state_d = LK_LOCKED;  // DISARM
            end
            LK_OPEN: begin
                if (set_wr) state_d = LK_LOCKED;       // RELOCK
            end
            default: state_d = LK_LOCKED;
        endcase
    end

    always_comb begin
        locked = (state_q != LK_OPEN);
        armed  = (state_q == LK_ARMED);
    end

    p_open_from_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_OPEN && $past(state_q) != LK_OPEN) |-> $past(state_q) == LK_ARMED);
    p_arm_consumed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == LK_ARMED && $past(any_wr) && !$past(key_wr)) |-> state_q != LK_ARMED);
    p_lock_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_wr) |-> locked);
endmodule

// File: rtl/trig_decode.sv
module trig_decode
    import cmd_trig_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [3:0]  rst_code,
    input  logic        ld_bit,
    input  logic        clr_bit,
    input  misc_pulse_t misc_bits,
    output logic        srst_pulse,
    output logic        ld_req,
    output logic        clr_req,
    output misc_pulse_t misc_pulse
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_pulse <= 1'b0;
            ld_req     <= 1'b0;
            clr_req    <= 1'b0;
            misc_pulse <= '0;
        end else if (cmd_wr) begin
            srst_pulse <= (rst_code == RESET_KEY);
            ld_req     <= ld_bit;
            clr_req    <= clr_bit;
            misc_pulse <= misc_bits;
        end else begin
            srst_pulse <= 1'b0;
            ld_req     <= 1'b0;
            clr_req    <= 1'b0;
            misc_pulse <= '0;
        end
    end

    p_srst_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        srst_pulse |-> ($past(cmd_wr) && $past(rst_code) == RESET_KEY));
endmodule

// File: rtl/chan_strobe.sv
module chan_strobe #(
    parameter int N_CH   = 4,
    parameter int CODE_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_wr,
    input  logic                     ld_bit,
    input  logic                     clr_bit,
    input  logic [N_CH-1:0]          sync_cfg,
    input  logic [N_CH-1:0]          clr_sel,
    output logic [N_CH-1:0]          load_pulse,
    output logic [N_CH-1:0]          clr_pulse,
    output logic [N_CH*CODE_W-1:0]   clr_code
);
    localparam logic [CODE_W-1:0] MID_CODE  = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] ZERO_CODE = '0;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic [CODE_W-1:0] code_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                load_pulse[i] <= 1'b0;
                clr_pulse[i]  <= 1'b0;
                code_q        <= ZERO_CODE;
            end else begin
                load_pulse[i] <= cmd_wr && ld_bit && !clr_bit && sync_cfg[i];
                clr_pulse[i]  <= cmd_wr && clr_bit;
                if (cmd_wr && clr_bit)
                    code_q <= clr_sel[i] ? MID_CODE : ZERO_CODE;
            end
        end

        assign clr_code[i*CODE_W +: CODE_W] = code_q;

        p_load_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
            load_pulse[i] |-> $past(sync_cfg[i]));
    end

    p_clr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_pulse) |-> (load_pulse == '0));
    p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|clr_pulse) |-> $stable(clr_code));
endmodule

// File: rtl/cmd_trig_reg.sv
module cmd_trig_reg
    import cmd_trig_pkg::*;
#(
    parameter int          N_CH     = 4,
    parameter int          CODE_W   = 12,
    parameter logic [7:0]  PAGE     = 8'hFF,
    parameter logic [7:0]  CMD_ADDR = 8'hE4,
    parameter logic [7:0]  CFG_ADDR = 8'hE3,
    parameter int          LOCK_BIT = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [7:0]              bus_page,
    input  logic [7:0]              bus_addr,
    input  logic [15:0]             bus_wdata,
    output logic [15:0]             bus_rdata,
    input  logic [N_CH-1:0]         sync_cfg,
    input  logic [N_CH-1:0]         clr_sel,
    output logic [N_CH-1:0]         load_pulse,
    output logic [N_CH-1:0]         clr_pulse,
    output logic [N_CH*CODE_W-1:0]  clr_code,
    output logic                    soft_rst_pulse,
    output logic                    fdump_pulse,
    output logic                    protect_pulse,
    output logic                    rdrow_pulse,
    output logic                    nvm_prog_pulse,
    output logic                    nvm_reload_pulse,
    output logic                    dev_locked
);
    logic        sel_cmd, sel_cfg, cmd_wr, cfg_wr;
    logic        armed, ld_req, clr_req;
    misc_pulse_t misc_bits, misc_pulse;
    logic        unused_wbit;

    assign sel_cmd = (bus_page == PAGE) && (bus_addr == CMD_ADDR);
    assign sel_cfg = (bus_page == PAGE) && (bus_addr == CFG_ADDR);
    assign cmd_wr  = bus_wr && sel_cmd;
    assign cfg_wr  = bus_wr && sel_cfg;
    assign unused_wbit = bus_wdata[5];

    assign misc_bits = '{fdump:      bus_wdata[4],
                         protect:    bus_wdata[3],
                         rdrow:      bus_wdata[2],
                         nvm_prog:   bus_wdata[1],
                         nvm_reload: bus_wdata[0]};

    lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_wr   (bus_wr),
        .key_wr   (cmd_wr && bus_wdata[15:12] == UNLOCK_KEY),
        .clear_wr (cfg_wr && !bus_wdata[LOCK_BIT]),
        .set_wr   (cfg_wr && bus_wdata[LOCK_BIT]),
        .locked   (dev_locked),
        .armed    (armed)
    );

    trig_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .rst_code   (bus_wdata[11:8]),
        .ld_bit     (bus_wdata[7]),
        .clr_bit    (bus_wdata[6]),
        .misc_bits  (misc_bits),
        .srst_pulse (soft_rst_pulse),
        .ld_req     (ld_req),
        .clr_req    (clr_req),
        .misc_pulse (misc_pulse)
    );

    chan_strobe #(.N_CH(N_CH), .CODE_W(CODE_W)) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .ld_bit     (bus_wdata[7]),
        .clr_bit    (bus_wdata[6]),
        .sync_cfg   (sync_cfg),
        .clr_sel    (clr_sel),
        .load_pulse (load_pulse),
        .clr_pulse  (clr_pulse),
        .clr_code   (clr_code)
    );

    assign fdump_pulse      = misc_pulse.fdump;
    assign protect_pulse    = misc_pulse.protect;
    assign rdrow_pulse      = misc_pulse.rdrow;
    assign nvm_prog_pulse   = misc_pulse.nvm_prog;
    assign nvm_reload_pulse = misc_pulse.nvm_reload;

    always_comb begin
        bus_rdata = '0;
        if (sel_cmd) begin
            bus_rdata[15:12] = armed ? UNLOCK_KEY : 4'h0;
            bus_rdata[11:8]  = soft_rst_pulse ? RESET_KEY : 4'h0;
            bus_rdata[7]     = ld_req;
            bus_rdata[6]     = clr_req;
            bus_rdata[4:0]   = misc_pulse;
        end else if (sel_cfg) begin
            bus_rdata[LOCK_BIT] = dev_locked;
        end
    end

    p_no_stray_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd_wr) |-> ({soft_rst_pulse, misc_pulse, load_pulse, clr_pulse} == '0));
endmodule

// File: tb/cmd_trig_reg_tb.sv
module cmd_trig_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_page = 8'h00;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic [3:0]  sync_cfg = 4'h0;
    logic [3:0]  clr_sel = 4'h0;
    logic [3:0]  load_pulse, clr_pulse;
    logic [47:0] clr_code;
    logic        soft_rst_pulse, fdump_pulse, protect_pulse, rdrow_pulse;
    logic        nvm_prog_pulse, nvm_reload_pulse, dev_locked;

    always #5 clk = ~clk;

    cmd_trig_reg dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_page(bus_page),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sync_cfg(sync_cfg), .clr_sel(clr_sel), .load_pulse(load_pulse),
        .clr_pulse(clr_pulse), .clr_code(clr_code), .soft_rst_pulse(soft_rst_pulse),
        .fdump_pulse(fdump_pulse), .protect_pulse(protect_pulse),
        .rdrow_pulse(rdrow_pulse), .nvm_prog_pulse(nvm_prog_pulse),
        .nvm_reload_pulse(nvm_reload_pulse), .dev_locked(dev_locked)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model: 0 locked, 1 armed, 2 open
    int          m_state = 0;
    logic [7:0]  m_bits = 8'h00;
    logic        m_srst = 1'b0;
    logic [3:0]  m_load = 4'h0, m_clr = 4'h0;
    logic [11:0] m_code [4] = '{12'h0, 12'h0, 12'h0, 12'h0};

    function automatic logic [15:0] exp_rdata();
        logic [15:0] r = 16'h0;
        if (bus_page == 8'hFF && bus_addr == 8'hE4) begin
            r[15:12] = (m_state == 1) ? 4'b0101 : 4'b0000;
            r[11:8]  = m_srst ? 4'b1010 : 4'b0000;
            r[7:0]   = m_bits;
        end else if (bus_page == 8'hFF && bus_addr == 8'hE3) begin
            r[0] = (m_state != 2);
        end
        return r;
    endfunction

    task automatic model_update(input logic w, input logic [7:0] pg, ad, input logic [15:0] d);
        bit wc = w && pg == 8'hFF && ad == 8'hE4;
        bit wg = w && pg == 8'hFF && ad == 8'hE3;
        bit key = wc && d[15:12] == 4'b0101;
        m_bits = wc ? (d[7:0] & 8'hDF) : 8'h00;
        m_srst = wc && d[11:8] == 4'b1010;
        for (int i = 0; i < 4; i++) begin
            m_load[i] = wc && d[7] && !d[6] && sync_cfg[i];
            m_clr[i]  = wc && d[6];
            if (wc && d[6]) m_code[i] = clr_sel[i] ? 12'h800 : 12'h000;
        end
        case (m_state)
            0: if (key) m_state = 1;
            1: if (wg && !d[0]) m_state = 2;
               else if (key) m_state = 1;
               else if (w) m_state = 0;
            default: if (wg && d[0]) m_state = 0;
        endcase
    endtask

    task automatic compare(input string tag);
        bit bad = 0;
        logic [47:0] ec = {m_code[3], m_code[2], m_code[1], m_code[0]};
        checks++;
        if (load_pulse !== m_load) begin bad = 1;
            $display("FAIL %s load_pulse act=%h exp=%h", tag, load_pulse, m_load); end
        if (clr_pulse !== m_clr) begin bad = 1;
            $display("FAIL %s clr_pulse act=%h exp=%h", tag, clr_pulse, m_clr); end
        if (clr_code !== ec) begin bad = 1;
            $display("FAIL %s clr_code act=%h exp=%h", tag, clr_code, ec); end
        if (soft_rst_pulse !== m_srst) begin bad = 1;
            $display("FAIL %s soft_rst_pulse act=%b exp=%b", tag, soft_rst_pulse, m_srst); end
        if ({fdump_pulse, protect_pulse, rdrow_pulse, nvm_prog_pulse, nvm_reload_pulse} !== m_bits[4:0]) begin
            bad = 1;
            $display("FAIL %s misc pulses act=%b exp=%b", tag,
                {fdump_pulse, protect_pulse, rdrow_pulse, nvm_prog_pulse, nvm_reload_pulse}, m_bits[4:0]); end
        if (dev_locked !== (m_state != 2)) begin bad = 1;
            $display("FAIL %s dev_locked act=%b exp=%b", tag, dev_locked, m_state != 2); end
        if (bus_rdata !== exp_rdata()) begin bad = 1;
            $display("FAIL %s bus_rdata act=%h exp=%h", tag, bus_rdata, exp_rdata()); end
        if (bad) errors++;
    endtask

    task automatic step(input logic w, input logic [7:0] pg, ad, input logic [15:0] d, input string tag);
        bus_wr = w; bus_page = pg; bus_addr = ad; bus_wdata = d;
        @(posedge clk);
        model_update(w, pg, ad, d);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wcmd(input logic [15:0] d, input string tag);
        step(1'b1, 8'hFF, 8'hE4, d, tag);
        step(1'b0, 8'hFF, 8'hE4, 16'h0, tag);   // pulse gone, readback 0
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 8'hFF, 8'hE4, 16'h0, "R1 reset");
        step(1'b0, 8'hFF, 8'hE3, 16'h0, "R1 reset lock");

        // R2 single-bit triggers, then all at once
        wcmd(16'h0001, "R2 reload");
        wcmd(16'h0002, "R2 prog");
        wcmd(16'h0004, "R2 rdrow");
        wcmd(16'h0008, "R2 protect");
        wcmd(16'h0010, "R2 fdump");
        wcmd(16'h003F, "R2 R10 all misc, bit5 reads 0");
        step(1'b1, 8'hFF, 8'hE4, 16'h0003, "R2 back-to-back a");
        step(1'b1, 8'hFF, 8'hE4, 16'h0010, "R2 back-to-back b");
        step(1'b0, 8'hFF, 8'hE4, 16'h0000, "R2 back-to-back idle");

        // R3 reset code
        wcmd(16'h0A00, "R3 reset key");
        wcmd(16'h0B00, "R3 wrong code");
        wcmd(16'h0F00, "R3 all ones");
        wcmd(16'h0200, "R3 partial");

        // R4 load gating
        sync_cfg = 4'b1010; wcmd(16'h0080, "R4 sync 1010");
        sync_cfg = 4'b1111; wcmd(16'h0080, "R4 sync 1111");
        sync_cfg = 4'b0000; wcmd(16'h0080, "R4 sync 0000");

        // R5 clear codes
        clr_sel = 4'b0110; wcmd(16'h0040, "R5 sel 0110");
        step(1'b0, 8'h00, 8'h00, 16'h0, "R5 code held");
        clr_sel = 4'b1001; wcmd(16'h0040, "R5 sel 1001");
        clr_sel = 4'b1111; wcmd(16'h0001, "R5 no clear keeps code");

        // R6 clear beats load
        sync_cfg = 4'b1111; clr_sel = 4'b0011; wcmd(16'h00C0, "R6 load+clear");

        // R11 other addresses
        wcmd(16'h0000, "R11 empty write");
        step(1'b1, 8'hFF, 8'hE5, 16'hFFFF, "R11 other addr");
        step(1'b1, 8'hFE, 8'hE4, 16'h0ADF, "R11 other page");
        step(1'b0, 8'hFF, 8'hE4, 16'h0, "R11 idle");

        // R8 without key, lock clear ignored
        step(1'b1, 8'hFF, 8'hE3, 16'h0000, "R8 clear without key");
        step(1'b1, 8'hFF, 8'hE4, 16'h6000, "R8 wrong key");
        step(1'b1, 8'hFF, 8'hE3, 16'h0000, "R8 clear after wrong key");
        // R8 arm consumed by unrelated write
        step(1'b1, 8'hFF, 8'hE4, 16'h5000, "R8 R10 arm");
        step(1'b0, 8'hFF, 8'hE4, 16'h0, "R10 armed readback");
        step(1'b1, 8'h10, 8'h20, 16'h1234, "R8 other write disarms");
        step(1'b1, 8'hFF, 8'hE3, 16'h0000, "R8 late clear ignored");

        // R7 unlock
        step(1'b1, 8'hFF, 8'hE4, 16'h5001, "R7 arm with reload");
        step(1'b1, 8'hFF, 8'hE4, 16'h5000, "R7 re-arm");
        step(1'b1, 8'hFF, 8'hE3, 16'h0000, "R7 unlock");
        step(1'b0, 8'hFF, 8'hE3, 16'h0, "R7 R10 cfg readback");
        step(1'b1, 8'hFF, 8'hE4, 16'h5000, "R7 key while open");

        // R9 relock, then lock set while armed
        step(1'b1, 8'hFF, 8'hE3, 16'h0001, "R9 relock");
        step(1'b1, 8'hFF, 8'hE4, 16'h5000, "R9 arm");
        step(1'b1, 8'hFF, 8'hE3, 16'h0001, "R9 set while armed");
        step(1'b0, 8'hFF, 8'hE3, 16'h0, "R9 cfg readback");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule